// File: doc/BRIEF.md
# Challenge-Gated Parity Key Generator

This block turns a fixed set of per-cell comparator decisions into a square key. It takes one snapshot of 32 comparator bits, where a bit is 1 when that cell reads below the reference conductance. It then consumes a stream of 32-bit challenge words. For every accepted challenge it forms one response bit. Each challenge bit switches on two event terms for its cell position. The first term fires when the cell and its neighbour sit on opposite sides of the reference. The second fires when the cell itself sits below the reference. The response bit is the odd/even parity of all enabled events.

A run begins with a start request. The block captures the comparator snapshot and clears the key. It then accepts exactly 100 challenges on a valid/ready handshake and places the response bits row by row into a 10 × 10 matrix. It signals completion with a one-cycle pulse and refuses further challenges until the next start request. The snapshot stays frozen for the whole run, so later activity on the comparator inputs cannot disturb a key that is half built.

Top module: `strong_puf_keygen`

## Requirements
- R1: After reset, `chalReady`, `respBit` and `donePulse` are 0 and every bit of `keyMatrix` is 0.
- R2: A start request seen while no run is active captures `cellBits` and clears `keyMatrix` to all zeros at the next edge. `chalReady` is 1 from the following cycle. Changes on `cellBits` after that edge do not affect any response of the run.
- R3: Event A at position n (0..31) is present when challenge bit n is 1 and captured cell bits n and n+1 differ. For n = 31 the neighbour is cell 0.
- R4: Event B at position n is present when challenge bit n is 1 and captured cell bit n is 1 (cell below reference).
- R5: The response to a challenge is 1 when the total number of A and B events over all 32 positions is odd, and 0 otherwise. An all-zero challenge therefore yields 0. The response is visible on `respBit` in the cycle after the accepting edge.
- R6: The k-th accepted challenge of a run (k = 0..99) writes its response to `keyMatrix[k]`, which is row k/10, column k mod 10. Rows fill in order from row 0, and columns fill in order from column 0 within a row.
- R7: The edge that accepts the 100th challenge drops `chalReady` and raises `donePulse` for exactly one cycle. After that, `chalValid` has no effect and `keyMatrix` holds its value.
- R8: A start request while a run is active is ignored, including in the cycle that accepts the 100th challenge. The captured cells, the fill position and the key are unchanged.
- R9: While no run is active, `chalValid` has no effect: `chalReady` stays 0 and neither `keyMatrix` nor `respBit` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a new 100-challenge run |
| cellBits | input | 32 | Comparator bits, 1 = cell conductance below reference |
| chalValid | input | 1 | Challenge word present |
| chalData | input | 32 | Challenge word; bit n enables position n |
| chalReady | output | 1 | Challenge accepted when high together with `chalValid` |
| respBit | output | 1 | Response of the most recently accepted challenge |
| keyMatrix | output | 100 | Key; bit k = row k/10, column k mod 10 |
| donePulse | output | 1 | One-cycle pulse after the 100th response is stored |

## Verification
Two events can land in the same cycle: a fresh start request and the acceptance of the last challenge. Both act on the run state, and start also clears the key. The bench raises `startReq` in exactly the cycle that carries the 100th challenge. It then checks that the done pulse appears, that `chalReady` falls, and that the full key equals the bench's own prediction instead of being cleared. A second collision, a start request in the middle of a run together with new comparator inputs, is judged by checking that the remaining responses are still predicted from the first snapshot.

// File: rtl/puf_pkg.sv
package puf_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadCells;   // capture comparator snapshot
    logic clearKey;    // zero the key matrix
    logic storeBit;    // write current response into the key
  } puf_strobe_t;
endpackage

// File: rtl/puf_event_parity.sv
module puf_event_parity #(
  parameter int CELLS = 32
) (
  input  logic [CELLS-1:0] cells,
  input  logic [CELLS-1:0] chal,
  output logic             parity
);
  logic [CELLS-1:0] pairEv;
  logic [CELLS-1:0] refEv;

  for (genvar n = 0; n < CELLS; n++) begin : g_pos
    localparam int NB = (n + 1) % CELLS;  // wrap-around neighbour
    assign pairEv[n] = chal[n] & (cells[n] ^ cells[NB]);
    assign refEv[n]  = chal[n] & cells[n];
  end

  assign parity = ^{pairEv, refEv};

  // Independent identity: pair and reference terms cancel on cell n,
  // leaving the parity of the gated neighbour bits (R5)
  always_comb begin
    if (!$isunknown({cells, chal}))
      p_parity_identity_r5: assert (parity == ^(chal & {cells[0], cells[CELLS-1:1]}));
  end
endmodule

// File: rtl/puf_control.sv
module puf_control
  import puf_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 10,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             chalValid,
  output logic             chalReady,
  output logic             donePulse,
  output puf_strobe_t      strobe,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic running;
  logic accept;
  logic lastSlot;
  logic startOk;

  assign accept   = running & chalValid;
  assign lastSlot = (row == ROW_W'(ROWS - 1)) && (col == COL_W'(COLS - 1));
  assign startOk  = !running && startReq;

  assign chalReady        = running;
  assign strobe.loadCells = startOk;
  assign strobe.clearKey  = startOk;
  assign strobe.storeBit  = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      row       <= '0;
      col       <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= accept && lastSlot;
      if (startOk) begin
        running <= 1'b1;
        row     <= '0;
        col     <= '0;
      end else if (accept) begin
        if (lastSlot) begin
          running <= 1'b0;
          row     <= '0;
          col     <= '0;
        end else if (col == COL_W'(COLS - 1)) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept && lastSlot |=> donePulse && !chalReady);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  p_slot_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (row < ROW_W'(ROWS)) && (col < COL_W'(COLS)));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    running && !(accept && lastSlot) |=> running);
  p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    !running && !startReq |=> !chalReady);
endmodule

// File: rtl/puf_datapath.sv
module puf_datapath
  import puf_pkg::*;
#(
  parameter int CELLS = 32,
  parameter int ROWS  = 10,
  parameter int COLS  = 10,
  localparam int STEPS = ROWS * COLS,
  localparam int IDX_W = $clog2(STEPS),
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  puf_strobe_t      strobe,
  input  logic [CELLS-1:0] cellBits,
  input  logic [CELLS-1:0] chalData,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [STEPS-1:0] keyMatrix,
  output logic             respBit
);
  logic [CELLS-1:0] cellLatch;
  logic [IDX_W-1:0] slotIdx;
  logic             parityBit;

  assign slotIdx = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);

  puf_event_parity #(.CELLS(CELLS)) i_events (
    .cells (cellLatch),
    .chal  (chalData),
    .parity(parityBit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellLatch <= '0;
      keyMatrix <= '0;
      respBit   <= 1'b0;
    end else begin
      if (strobe.loadCells) cellLatch <= cellBits;
      if (strobe.clearKey)  keyMatrix <= '0;
      else if (strobe.storeBit) keyMatrix[slotIdx] <= parityBit;
      if (strobe.storeBit) respBit <= parityBit;
    end
  end

  p_cells_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCells |=> $stable(cellLatch));
  p_key_cleared_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearKey |=> keyMatrix == '0);
  p_store_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeBit && !strobe.clearKey |=> keyMatrix[$past(slotIdx)] == $past(parityBit));
  p_key_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.storeBit && !strobe.clearKey |=> $stable(keyMatrix));
endmodule

// File: rtl/strong_puf_keygen.sv
module strong_puf_keygen
  import puf_pkg::*;
#(
  parameter int CELLS = 32,
  parameter int ROWS  = 10,
  parameter int COLS  = 10,
  localparam int STEPS = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CELLS-1:0] cellBits,
  input  logic             chalValid,
  input  logic [CELLS-1:0] chalData,
  output logic             chalReady,
  output logic             respBit,
  output logic [STEPS-1:0] keyMatrix,
  output logic             donePulse
);
  puf_strobe_t      strobe;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  puf_control #(.ROWS(ROWS), .COLS(COLS)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .chalValid(chalValid),
    .chalReady(chalReady),
    .donePulse(donePulse),
    .strobe   (strobe),
    .row      (row),
    .col      (col)
  );

  puf_datapath #(.CELLS(CELLS), .ROWS(ROWS), .COLS(COLS)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cellBits (cellBits),
    .chalData (chalData),
    .row      (row),
    .col      (col),
    .keyMatrix(keyMatrix),
    .respBit  (respBit)
  );
endmodule

// File: tb/test_strong_puf_keygen.sv
module test_strong_puf_keygen;
  localparam int CELLS = 32;
  localparam int STEPS = 100;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [CELLS-1:0]  cellBits = '0;
  logic              chalValid = 1'b0;
  logic [CELLS-1:0]  chalData = '0;
  logic              chalReady;
  logic              respBit;
  logic [STEPS-1:0]  keyMatrix;
  logic              donePulse;

  int nChecks = 0;
  int nFails  = 0;
  logic [STEPS-1:0] expKey;
  logic [CELLS-1:0] snap;

  always #10 clk = ~clk;  // 50 MHz

  strong_puf_keygen i_strong_puf_keygen (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cellBits(cellBits),
    .chalValid(chalValid), .chalData(chalData), .chalReady(chalReady),
    .respBit(respBit), .keyMatrix(keyMatrix), .donePulse(donePulse)
  );

  // Reference built from the two event definitions
  function automatic logic refResp(input logic [CELLS-1:0] c, input logic [CELLS-1:0] ch);
    int events = 0;
    for (int n = 0; n < CELLS; n++) begin
      if (ch[n] && (c[n] != c[(n + 1) % CELLS])) events++;  // R3
      if (ch[n] && c[n]) events++;                         // R4
    end
    return logic'(events % 2);                             // R5
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CELLS-1:0] pickChal(input int k);
    case (k)
      0: return '0;                  // R5 zero challenge
      1: return 32'h8000_0000;       // R3 wrap position only
      2: return '1;
      3: return 32'h0000_0001;
      4: return 32'h4000_0000;
      default: return $urandom;
    endcase
  endfunction

  // Runs one full sequence of STEPS accepted challenges
  task automatic runSequence(input int validPct, input logic midStart, input logic endStart);
    int k = 0;
    logic prevAcc = 1'b0;
    while (k < STEPS) begin
      @(negedge clk);
      cellBits = $urandom;  // R2: must not matter after capture
      startReq = 1'b0;
      if (prevAcc)
        check(respBit == expKey[k-1], "R5 response bit", 128'(respBit), 128'(expKey[k-1]));
      check(chalReady == 1'b1, "R7 ready during run", 128'(chalReady), 128'(1));
      prevAcc = (($urandom % 100) < validPct);
      chalValid = prevAcc;
      chalData  = prevAcc ? pickChal(k) : CELLS'($urandom);
      if (prevAcc) begin
        if (midStart && k == 50) startReq = 1'b1;            // R8 mid-run
        if (endStart && k == STEPS - 1) startReq = 1'b1;     // R8 with final accept
        expKey[k] = refResp(snap, chalData);
        k++;
      end
    end
    @(negedge clk);
    startReq  = 1'b0;
    chalValid = 1'b1;
    chalData  = $urandom;
    check(respBit == expKey[STEPS-1], "R5 last response", 128'(respBit), 128'(expKey[STEPS-1]));
    check(donePulse == 1'b1, "R7 done pulse", 128'(donePulse), 128'(1));
    check(chalReady == 1'b0, "R7 ready drops", 128'(chalReady), 128'(0));
    check(keyMatrix == expKey, "R6 key layout", 128'(keyMatrix), 128'(expKey));
    @(negedge clk);
    check(donePulse == 1'b0, "R7 single pulse", 128'(donePulse), 128'(1'b0));
    check(keyMatrix == expKey, "R7 key held", 128'(keyMatrix), 128'(expKey));
    check(respBit == expKey[STEPS-1], "R9 resp held", 128'(respBit), 128'(expKey[STEPS-1]));
    chalValid = 1'b0;
  endtask

  task automatic startRun(input logic [CELLS-1:0] cells);
    @(negedge clk);
    cellBits = cells;
    startReq = 1'b1;
    snap     = cells;
    @(negedge clk);
    startReq = 1'b0;
    check(keyMatrix == '0, "R2 key cleared", 128'(keyMatrix), 128'(0));
    check(chalReady == 1'b1, "R2 ready after start", 128'(chalReady), 128'(1));
  endtask

  initial begin
    void'($urandom(32'h5A17_C3E1));
    expKey = '0;
    repeat (3) @(negedge clk);
    check(chalReady == 1'b0 && donePulse == 1'b0 && respBit == 1'b0, "R1 reset outputs",
          128'({chalReady, donePulse, respBit}), 128'(0));
    check(keyMatrix == '0, "R1 reset key", 128'(keyMatrix), 128'(0));
    rstN = 1'b1;

    // R9: valid while idle
    chalValid = 1'b1;
    chalData  = '1;
    repeat (4) @(negedge clk);
    check(chalReady == 1'b0, "R9 idle ready", 128'(chalReady), 128'(0));
    check(keyMatrix == '0 && respBit == 1'b0, "R9 idle no store",
          128'({keyMatrix, respBit}), 128'(0));
    chalValid = 1'b0;

    // Run 1: cell 0 set, cell 31 clear so wrap case yields 1 (R3)
    startRun(32'h1234_5671);
    runSequence(70, 1'b1, 1'b1);

    // Start collided with the final accept: must stay idle (R8)
    repeat (2) @(negedge clk);
    check(chalReady == 1'b0, "R8 end start ignored", 128'(chalReady), 128'(0));
    check(keyMatrix == expKey, "R8 key kept", 128'(keyMatrix), 128'(expKey));

    // Run 2: new snapshot, back-to-back challenges
    expKey = '0;
    startRun(32'hA5C3_0F96);
    runSequence(100, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule